// File: doc/BRIEF.md
# Next-PC Branch and Jump Unit

This block chooses the address of the next instruction for a 32-bit processor whose instructions are all one word long and word aligned. Each cycle it looks at the instruction word at the current PC. From that word it sorts the instruction into a transfer class. It then builds the next PC from one of four sources: the incremented PC, a word-scaled relative branch target, a jump target inside the current 256 MiB region, or a full 32-bit address read from a register. A register holds the PC. The register loads a parameterised reset vector on a synchronous reset and otherwise takes the computed next PC on every clock edge.

The surrounding pipeline supplies three things: the instruction word, the result of an equality compare between the two source registers, and the value of the source register used for indirect jumps. For the two linking jumps the block also raises a write request. That request carries the address of the following instruction, destined for register 31. The decoder has five transfer classes: SEQ (no transfer), BR_EQ, BR_NE, JMP_REGION and JMP_REG. Each class chooses exactly one source. The PC register has two transitions: RESET (load the vector) and ADVANCE (load the next PC).

Top module: `next_pc_unit`

## Requirements
- R1: When `rst` is high at a clock edge, `pc_q` becomes `RESET_VEC` (default 0x0040_0000), whatever instruction is presented.
- R2: An instruction whose opcode `instr_word[31:26]` is not a control transfer gives `pc_next = pc_q + 4` and `link_we = 0`, whatever the values of `ops_equal` and `reg_target`.
- R3: Opcode 000100 (branch-if-equal) with `ops_equal = 1` gives `pc_next = pc_q + 4 + (sign-extended instr_word[15:0] << 2)`. With `ops_equal = 0` it gives `pc_q + 4`.
- R4: Opcode 000101 (branch-if-not-equal) takes the same target when `ops_equal = 0`, and falls through to `pc_q + 4` when `ops_equal = 1`.
- R5: A branch displacement with bit 15 set moves backward. For example, 0xFFFB taken from `pc_q` gives `pc_q + 4 - 20`.
- R6: Opcode 000010 (jump) gives `pc_next = {pc_q[31:28], instr_word[25:0], 2'b00}`. The upper four bits come from `pc_q` itself, not from `pc_q + 4`. No link is requested.
- R7: Opcode 000011 (jump-and-link) forms the R6 target. It also sets `link_we = 1`, `link_reg = 31` and `link_data = pc_q + 4`.
- R8: Opcode 000000 with function `instr_word[5:0] = 001000` (register jump) gives `pc_next = reg_target` and no link.
- R9: Opcode 000000 with function 001001 (register jump-and-link) gives `pc_next = reg_target`, `link_we = 1`, `link_reg = 31` and `link_data = pc_q + 4`.
- R10: Opcode 000000 with any other function code is sequential: `pc_q + 4`, no link.
- R11: When `rst` is low, `pc_q` takes the value `pc_next` had before each clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| instr_word | input | 32 | Instruction fetched at `pc_q` |
| ops_equal | input | 1 | High when the two source registers are equal |
| reg_target | input | 32 | Source register value used by register jumps |
| pc_q | output | 32 | Current program counter |
| pc_next | output | 32 | Combinational next program counter |
| link_we | output | 1 | Return-address write request |
| link_reg | output | 5 | Destination register of the link write (31) |
| link_data | output | 32 | Return address, `pc_q + 4` |

## Verification
The bench targets the following cases:
- **Both branch senses, taken and not taken.** A design with the senses swapped branches in the wrong cases.
- **A negative displacement.** Zero-extending it would send the PC far forward instead of back 5 words.
- **A region jump placed at 0x0FFF_FFFC.** Here the incremented PC crosses into the next region, so taking the top nibble from `pc_q + 4` rather than `pc_q` lands 256 MiB away.
- **Function codes near the register-jump codes under opcode zero.** A loose function decode turns an ordinary arithmetic operation into a jump.
- **Reset mid-run while a jump is presented.** This catches a reset that loses priority to the jump.

// File: rtl/npc_pkg.sv
package npc_pkg;
    localparam int unsigned XW   = 32;
    localparam int unsigned OPW  = 6;
    localparam int unsigned FNW  = 6;
    localparam int unsigned IMMW = 16;
    localparam int unsigned JFW  = 26;
    localparam int unsigned RIDW = 5;

    localparam logic [OPW-1:0] OPC_SPECIAL  = 6'b000000;
    localparam logic [OPW-1:0] OPC_BR_EQ    = 6'b000100;
    localparam logic [OPW-1:0] OPC_BR_NE    = 6'b000101;
    localparam logic [OPW-1:0] OPC_JUMP     = 6'b000010;
    localparam logic [OPW-1:0] OPC_JUMP_LNK = 6'b000011;
    localparam logic [FNW-1:0] FN_REG_JUMP     = 6'b001000;
    localparam logic [FNW-1:0] FN_REG_JUMP_LNK = 6'b001001;

    typedef enum logic [2:0] {
        XFER_SEQ,
        XFER_BR_EQ,
        XFER_BR_NE,
        XFER_JMP_REGION,
        XFER_JMP_REG
    } xfer_e;
endpackage

// File: rtl/npc_decode.sv
module npc_decode
    import npc_pkg::*;
(
    input  logic [OPW-1:0] opc,
    input  logic [FNW-1:0] funct,
    output xfer_e          kind,
    output logic           link
);
    always_comb begin
        kind = XFER_SEQ;
        link = 1'b0;
        unique case (opc)
            OPC_BR_EQ:    kind = XFER_BR_EQ;
            OPC_BR_NE:    kind = XFER_BR_NE;
            OPC_JUMP:     kind = XFER_JMP_REGION;
            OPC_JUMP_LNK: begin
                kind = XFER_JMP_REGION;
                link = 1'b1;
            end
            OPC_SPECIAL: begin
                unique case (funct)
                    FN_REG_JUMP:     kind = XFER_JMP_REG;
                    FN_REG_JUMP_LNK: begin
                        kind = XFER_JMP_REG;
                        link = 1'b1;
                    end
                    default: kind = XFER_SEQ;
                endcase
            end
            default: kind = XFER_SEQ;
        endcase
    end
endmodule

// File: rtl/npc_targets.sv
module npc_targets
    import npc_pkg::*;
(
    input  logic [XW-1:0]  pc,
    input  logic [JFW-1:0] field,
    output logic [XW-1:0]  seq_pc,
    output logic [XW-1:0]  branch_pc,
    output logic [XW-1:0]  region_pc
);
    localparam int unsigned SEXT = XW - IMMW;
    localparam int unsigned KEEP = XW - JFW - 2;

    logic [IMMW-1:0] disp;
    logic [XW-1:0]   disp_words;

    assign disp       = field[IMMW-1:0];
    assign disp_words = {{SEXT{disp[IMMW-1]}}, disp};
    assign seq_pc     = pc + XW'(4);
    assign branch_pc  = seq_pc + (disp_words << 2);
    assign region_pc  = {pc[XW-1 -: KEEP], field, 2'b00};
endmodule

// File: rtl/npc_select.sv
module npc_select
    import npc_pkg::*;
(
    input  xfer_e         kind,
    input  logic          ops_equal,
    input  logic [XW-1:0] seq_pc,
    input  logic [XW-1:0] branch_pc,
    input  logic [XW-1:0] region_pc,
    input  logic [XW-1:0] reg_target,
    output logic [XW-1:0] next_pc
);
    always_comb begin
        unique case (kind)
            XFER_BR_EQ:      next_pc = ops_equal  ? branch_pc : seq_pc;
            XFER_BR_NE:      next_pc = !ops_equal ? branch_pc : seq_pc;
            XFER_JMP_REGION: next_pc = region_pc;
            XFER_JMP_REG:    next_pc = reg_target;
            default:         next_pc = seq_pc;
        endcase
    end
endmodule

// File: rtl/next_pc_unit.sv
module next_pc_unit
    import npc_pkg::*;
#(
    parameter logic [31:0] RESET_VEC = 32'h0040_0000,
    parameter int unsigned LINK_IDX  = 31
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [31:0] instr_word,
    input  logic        ops_equal,
    input  logic [31:0] reg_target,
    output logic [31:0] pc_q,
    output logic [31:0] pc_next,
    output logic        link_we,
    output logic [4:0]  link_reg,
    output logic [31:0] link_data
);
    xfer_e       kind;
    logic        link;
    logic [31:0] seq_pc;
    logic [31:0] branch_pc;
    logic [31:0] region_pc;

    npc_decode u_decode (
        .opc   (instr_word[31:26]),
        .funct (instr_word[5:0]),
        .kind  (kind),
        .link  (link)
    );

    npc_targets u_targets (
        .pc        (pc_q),
        .field     (instr_word[25:0]),
        .seq_pc    (seq_pc),
        .branch_pc (branch_pc),
        .region_pc (region_pc)
    );

    npc_select u_select (
        .kind       (kind),
        .ops_equal  (ops_equal),
        .seq_pc     (seq_pc),
        .branch_pc  (branch_pc),
        .region_pc  (region_pc),
        .reg_target (reg_target),
        .next_pc    (pc_next)
    );

    // PC register: RESET and ADVANCE transitions
    always_ff @(posedge clk) begin
        if (rst) pc_q <= RESET_VEC;
        else     pc_q <= pc_next;
    end

    // Link outputs
    always_comb begin
        link_we   = link;
        link_reg  = RIDW'(LINK_IDX);
        link_data = seq_pc;
    end

    a_r1_reset_vector: assert property (@(posedge clk)
        rst |=> pc_q == RESET_VEC);

    a_r11_pc_follows: assert property (@(posedge clk) disable iff (rst)
        !rst |=> pc_q == $past(pc_next));

    a_r2_seq_step: assert property (@(posedge clk) disable iff (rst)
        kind == XFER_SEQ |-> (pc_next == pc_q + 32'd4 && !link_we));

    a_r6_region_keeps_top: assert property (@(posedge clk) disable iff (rst)
        kind == XFER_JMP_REGION |-> (pc_next[31:28] == pc_q[31:28] && pc_next[1:0] == 2'b00));

    a_r8_reg_target: assert property (@(posedge clk) disable iff (rst)
        kind == XFER_JMP_REG |-> pc_next == reg_target);

    a_r7_link_return: assert property (@(posedge clk) disable iff (rst)
        link_we |-> (link_data == pc_q + 32'd4 && link_reg == 5'd31));
endmodule

// File: tb/test_next_pc_unit.sv
`timescale 1ns/1ps
module test_next_pc_unit;
    localparam logic [31:0] RV = 32'h0040_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] instr_word = 32'h0;
    logic        ops_equal = 1'b0;
    logic [31:0] reg_target = 32'h0;
    logic [31:0] pc_q, pc_next, link_data;
    logic        link_we;
    logic [4:0]  link_reg;

    int n_run = 0;
    int n_fail = 0;
    logic [31:0] exp_q[$];
    logic [31:0] model_pc;
    bit done = 0;

    always #2.5 clk = ~clk;

    next_pc_unit #(.RESET_VEC(RV)) i_next_pc_unit (
        .clk(clk), .rst(rst), .instr_word(instr_word), .ops_equal(ops_equal),
        .reg_target(reg_target), .pc_q(pc_q), .pc_next(pc_next),
        .link_we(link_we), .link_reg(link_reg), .link_data(link_data)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_next(input logic [31:0] pc, input logic [31:0] ins,
                                             input logic eq, input logic [31:0] tgt);
        logic [31:0] inc, br;
        inc = pc + 32'd4;
        br  = inc + ({{16{ins[15]}}, ins[15:0]} << 2);
        case (ins[31:26])
            6'b000100: return eq ? br : inc;
            6'b000101: return eq ? inc : br;
            6'b000010, 6'b000011: return {pc[31:28], ins[25:0], 2'b00};
            6'b000000: return (ins[5:0] == 6'b001000 || ins[5:0] == 6'b001001) ? tgt : inc;
            default: return inc;
        endcase
    endfunction

    function automatic bit ref_link(input logic [31:0] ins);
        return ins[31:26] == 6'b000011 ||
               (ins[31:26] == 6'b000000 && ins[5:0] == 6'b001001);
    endfunction

    // Driver: applies one instruction, checks combinational outputs, queues the PC expectation
    task automatic step(input logic [31:0] ins, input logic eq, input logic [31:0] tgt, input string req);
        logic [31:0] e;
        bit lk;
        @(negedge clk);
        rst = 1'b0; instr_word = ins; ops_equal = eq; reg_target = tgt;
        #1;
        e  = ref_next(model_pc, ins, eq, tgt);
        lk = ref_link(ins);
        chk(pc_next === e, req, pc_next, e);
        chk(link_we === lk, req, {31'd0, link_we}, {31'd0, lk});
        if (lk) begin
            chk(link_data === model_pc + 32'd4, req, link_data, model_pc + 32'd4);
            chk(link_reg === 5'd31, req, {27'd0, link_reg}, 32'd31);
        end
        exp_q.push_back(e);
        model_pc = e;
    endtask

    // Monitor: compares the registered PC after each edge (R11, R1)
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            logic [31:0] e;
            e = exp_q.pop_front();
            chk(pc_q === e, "R11 pc_q", pc_q, e);
        end
    end

    initial begin
        #(200000 * 5);
        chk(1'b0, "watchdog", 32'h0, 32'h1);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        model_pc = RV;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk(pc_q === RV, "R1 reset state", pc_q, RV);

        step(32'h0022_1820, 1'b1, 32'hDEAD_BEEC, "R10 arith under opcode 0");
        step(32'h8D28_0004, 1'b1, 32'h1234_5678, "R2 non-transfer");
        step(32'h1043_0003, 1'b1, 32'h0, "R3 eq taken");
        step(32'h1043_0003, 1'b0, 32'h0, "R3 eq not taken");
        step(32'h1443_FFFB, 1'b0, 32'h0, "R4 R5 ne taken backward");
        step(32'h1443_FFFB, 1'b1, 32'h0, "R4 ne not taken");
        step(32'h1043_FFFF, 1'b1, 32'h0, "R5 eq backward one word");
        step(32'h0812_3456, 1'b0, 32'hFFFF_FFF0, "R6 region jump");
        step(32'h0C00_0100, 1'b1, 32'h0, "R7 jump and link");
        step(32'h0060_0008, 1'b0, 32'h0FFF_FFFC, "R8 register jump");
        step(32'h0800_0010, 1'b0, 32'h0, "R6 top nibble from pc not pc+4");
        step(32'h0060_F809, 1'b1, 32'h0000_1000, "R9 register jump and link");
        step(32'h0060_000A, 1'b0, 32'h0000_2000, "R10 function near register jump");
        step(32'h1000_FFFF, 1'b0, 32'h0, "R3 eq not taken negative disp");

        // Mid-run reset with a jump presented (R1)
        @(negedge clk);
        rst = 1'b1; instr_word = 32'h0BFF_FFFF; ops_equal = 1'b0;
        exp_q.push_back(RV);
        model_pc = RV;
        step(32'h0000_0000, 1'b0, 32'h0, "R2 after reset");
        step(32'h1400_0002, 1'b0, 32'h0, "R4 ne taken after reset");

        @(posedge clk);
        #2;
        chk(exp_q.size() == 0, "R11 queue drained", exp_q.size(), 32'h0);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule